// File: doc/BRIEF.md
# Twelve-Hour BCD Time-of-Day Counter

This block keeps time of day as six BCD digits (hours, minutes, seconds) plus a morning/afternoon flag. It advances by one second on every system clock cycle in which the one-cycle `tick` enable is high. All digits are registers on the one system clock. Each stage passes its carry to the next as an enable in the same cycle, so the outputs never show a partial carry.

Seconds and minutes each use a units digit that counts 0 to 9 and a tens digit that counts 0 to 5. Hours run 12, 01, 02 … 11 and back to 12. The increment that would give 13 is caught at once and replaced by 01, so 13 never reaches a register. The `pm` flag flips when the hours step from 11 to 12. A load strobe writes the hours and minutes and clears the seconds. If any field of the load is out of range, the load is dropped and the cycle behaves as if the strobe were low.

Top module: `hms_clock12`

## Requirements
- R1: While `rst_n` is low at a clock edge, the time becomes 12:00:00 with `pm`=0, whatever `tick` and `set_en` are.
- R2: At an edge where `tick` is low and no valid load is presented, every output keeps its value.
- R3: At each edge where `tick` is high, the seconds units digit steps up by one. It goes from 9 to 0 and then carries into the seconds tens digit.
- R4: The seconds tens digit counts 0 to 5. Stepping past 59 seconds gives 00 and advances the minutes by one in the same edge.
- R5: The minutes count 00 to 59 (units 0–9, tens 0–5). Stepping past 59:59 gives 00:00 and advances the hours in the same edge.
- R6: The hours follow 12, 01, 02 … 11, 12. The hour after 12 is 01 (tens 0, units 1). Hours 00 and 13 never appear on the outputs.
- R7: `pm` inverts only when the hours step from 11 to 12. A full day of ticks from 12:00:00 with `pm`=0 returns to 12:00:00 with `pm`=0.
- R8: With `set_en` high and valid fields, the next edge loads the hours from `set_hr_t`/`set_hr_u` and the minutes from `set_min_t`/`set_min_u`. It sets the seconds to 00 and leaves `pm` as it was. A valid load takes priority over `tick`.
- R9: A load is invalid if the hours, read as BCD, fall outside 1–12, or the minutes fall outside 00–59 (a tens digit above 5 or a units digit above 9). An invalid load changes nothing. A `tick` in the same cycle still advances the time by one second.
- R10: At all times the seconds and minutes tens digits are at most 5, the units digits are at most 9, and the hours read 01–12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-second advance enable, one cycle wide |
| set_en | input | 1 | Load strobe for hours and minutes |
| set_hr_t | input | 4 | Hours tens digit to load (BCD) |
| set_hr_u | input | 4 | Hours units digit to load (BCD) |
| set_min_t | input | 4 | Minutes tens digit to load (BCD) |
| set_min_u | input | 4 | Minutes units digit to load (BCD) |
| sec_u | output | 4 | Seconds units digit |
| sec_t | output | 4 | Seconds tens digit |
| min_u | output | 4 | Minutes units digit |
| min_t | output | 4 | Minutes tens digit |
| hr_u | output | 4 | Hours units digit |
| hr_t | output | 4 | Hours tens digit |
| pm | output | 1 | 0 for the first half of the day, 1 for the second |

## Verification
Every result is due one clock edge after its stimulus: a tick, load or reset seen at edge N shows on the outputs right after edge N. A carry all the way from seconds to `pm` needs no extra cycle. The bench changes inputs on falling edges and reads outputs on the next falling edge, half a period after the edge that updates them. A model of seconds since midnight advances in step with the same edges and gives the expected values. Every cycle of a full 86,400-tick day is compared, each compare tagged by the carry it crosses.

// File: rtl/hms_clock12_pkg.sv
// Shared widths and constants for the twelve-hour time counter.
// Assumes every digit is held as a 4-bit BCD code.
package hms_clock12_pkg;
    localparam int DIGIT_W  = 4;
    localparam int LOW_DIGS = 4;   // seconds units/tens, minutes units/tens
    localparam int UNIT_MOD = 10;
    localparam int TENS_MOD = 6;
    typedef logic [DIGIT_W-1:0] bcd_t;
endpackage

// File: rtl/hms_bcd_digit.sv
// One modulo-MODULUS BCD digit with enable, synchronous load and carry out.
// Assumes load and inc are never meant to act together; load wins.
// wrap is combinational: high when inc would take the digit from its top value to 0.
module hms_bcd_digit #(
    parameter int MODULUS = 10,
    parameter int W       = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] q,
    output logic         wrap
);
    localparam logic [W-1:0] TOP = W'(MODULUS - 1);

    // Carry to the next digit when stepping past the top value.
    assign wrap = inc && (q == TOP);

    // Digit register: reset to zero, load, or count modulo MODULUS.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= load_val;
        else if (inc)
            q <= (q == TOP) ? '0 : q + W'(1);
    end
endmodule

// File: rtl/hms_hour_stage.sv
// Hours pair (12,01..11) and the morning/afternoon flag.
// Assumes load values are already checked to lie in 01..12.
// A BCD increment that would give 13 is replaced by 01 in the same cycle.
module hms_hour_stage
    import hms_clock12_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic load,
    input  bcd_t load_t,
    input  bcd_t load_u,
    output bcd_t hr_t,
    output bcd_t hr_u,
    output logic pm
);
    bcd_t raw_t, raw_u, nxt_t, nxt_u;
    logic at_eleven;

    // Plain BCD increment of the hour pair, then the 13-to-01 correction.
    always_comb begin
        if (hr_u == bcd_t'(9)) begin
            raw_t = hr_t + bcd_t'(1);
            raw_u = '0;
        end else begin
            raw_t = hr_t;
            raw_u = hr_u + bcd_t'(1);
        end
        if (raw_t == bcd_t'(1) && raw_u == bcd_t'(3)) begin
            nxt_t = '0;
            nxt_u = bcd_t'(1);
        end else begin
            nxt_t = raw_t;
            nxt_u = raw_u;
        end
    end

    assign at_eleven = (hr_t == bcd_t'(1)) && (hr_u == bcd_t'(1));

    // Hour registers and flag: reset to 12 AM, load, or advance on carry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hr_t <= bcd_t'(1);
            hr_u <= bcd_t'(2);
            pm   <= 1'b0;
        end else if (load) begin
            hr_t <= load_t;
            hr_u <= load_u;
        end else if (inc) begin
            hr_t <= nxt_t;
            hr_u <= nxt_u;
            if (at_eleven)
                pm <= ~pm;
        end
    end
endmodule

// File: rtl/hms_clock12.sv
// Twelve-hour BCD time-of-day counter: seconds, minutes, hours and a pm flag.
// Assumes tick is one system-clock cycle wide per second.
// Carries ripple as same-cycle enables; a valid load overrides tick.
module hms_clock12
    import hms_clock12_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               set_en,
    input  logic [DIGIT_W-1:0] set_hr_t,
    input  logic [DIGIT_W-1:0] set_hr_u,
    input  logic [DIGIT_W-1:0] set_min_t,
    input  logic [DIGIT_W-1:0] set_min_u,
    output logic [DIGIT_W-1:0] sec_u,
    output logic [DIGIT_W-1:0] sec_t,
    output logic [DIGIT_W-1:0] min_u,
    output logic [DIGIT_W-1:0] min_t,
    output logic [DIGIT_W-1:0] hr_u,
    output logic [DIGIT_W-1:0] hr_t,
    output logic               pm
);
    logic hr_ok, min_ok, set_ok, adv;
    logic [LOW_DIGS:0]  chain;
    logic [LOW_DIGS-1:0] wraps;
    bcd_t dig_q  [LOW_DIGS];
    bcd_t dig_ld [LOW_DIGS];

    // Range check of the load fields: hours 01..12, minutes 00..59.
    always_comb begin
        hr_ok  = ((set_hr_t == '0) && (set_hr_u != '0) && (set_hr_u <= bcd_t'(9)))
              || ((set_hr_t == bcd_t'(1)) && (set_hr_u <= bcd_t'(2)));
        min_ok = (set_min_t <= bcd_t'(TENS_MOD - 1)) && (set_min_u <= bcd_t'(UNIT_MOD - 1));
        set_ok = set_en && hr_ok && min_ok;
    end

    assign adv      = tick && !set_ok;
    assign chain[0] = adv;

    // Load values for the low digits: seconds cleared, minutes from the port.
    assign dig_ld[0] = '0;
    assign dig_ld[1] = '0;
    assign dig_ld[2] = set_min_u;
    assign dig_ld[3] = set_min_t;

    // Even positions are decade units, odd positions are mod-6 tens.
    for (genvar i = 0; i < LOW_DIGS; i++) begin : g_low
        localparam int MOD = (i % 2 == 0) ? UNIT_MOD : TENS_MOD;
        hms_bcd_digit #(.MODULUS(MOD), .W(DIGIT_W)) u_dig (
            .clk      (clk),
            .rst_n    (rst_n),
            .inc      (chain[i]),
            .load     (set_ok),
            .load_val (dig_ld[i]),
            .q        (dig_q[i]),
            .wrap     (wraps[i])
        );
        assign chain[i+1] = wraps[i];
    end

    hms_hour_stage u_hours (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (chain[LOW_DIGS]),
        .load   (set_ok),
        .load_t (set_hr_t),
        .load_u (set_hr_u),
        .hr_t   (hr_t),
        .hr_u   (hr_u),
        .pm     (pm)
    );

    assign sec_u = dig_q[0];
    assign sec_t = dig_q[1];
    assign min_u = dig_q[2];
    assign min_t = dig_q[3];
endmodule

// File: rtl/hms_clock12_checks.sv
// Property checker for hms_clock12, attached by bind below.
// Assumes only the top-level ports; reads no internal state.
module hms_clock12_checks (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       set_en,
    input logic [3:0] set_hr_t,
    input logic [3:0] set_hr_u,
    input logic [3:0] set_min_t,
    input logic [3:0] set_min_u,
    input logic [3:0] sec_u,
    input logic [3:0] sec_t,
    input logic [3:0] min_u,
    input logic [3:0] min_t,
    input logic [3:0] hr_u,
    input logic [3:0] hr_t,
    input logic       pm
);
    logic [24:0] now;
    logic        at_5959, bad_hr_field;
    assign now          = {hr_t, hr_u, min_t, min_u, sec_t, sec_u, pm};
    assign at_5959      = (min_t == 4'd5) && (min_u == 4'd9) && (sec_t == 4'd5) && (sec_u == 4'd9);
    assign bad_hr_field = (set_hr_t > 4'd1) || (set_min_t > 4'd5) || (set_min_u > 4'd9);

    // R1: reset yields 12:00:00 AM on the next edge.
    assert_reset_time_R1: assert property (@(posedge clk)
        !rst_n |=> (now == {4'd1, 4'd2, 4'd0, 4'd0, 4'd0, 4'd0, 1'b0}));

    // R2: no tick and no load keeps all state.
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !set_en) |=> $stable(now));

    // R3: units digit of seconds wraps 9 to 0.
    assert_units_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !set_en && sec_u == 4'd9) |=> (sec_u == 4'd0));

    // R4: seconds 59 wraps to 00.
    assert_sec_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !set_en && sec_t == 4'd5 && sec_u == 4'd9) |=> (sec_t == 4'd0 && sec_u == 4'd0));

    // R5: 59:59 wraps to 00:00.
    assert_min_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !set_en && at_5959) |=> (min_t == 4'd0 && min_u == 4'd0));

    // R6: hour after 12 is 01.
    assert_hour_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !set_en && at_5959 && hr_t == 4'd1 && hr_u == 4'd2) |=> (hr_t == 4'd0 && hr_u == 4'd1));

    // R7: pm only changes when arriving at 12:00:00.
    assert_pm_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pm) |-> (hr_t == 4'd1 && hr_u == 4'd2 && min_t == 4'd0 && min_u == 4'd0
                          && sec_t == 4'd0 && sec_u == 4'd0));

    // R9: an out-of-range load without a tick leaves the time unchanged.
    assert_bad_set_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && bad_hr_field && !tick) |=> $stable(now));

    // R10: every digit is in its legal range.
    assert_digit_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_u <= 4'd9) && (sec_t <= 4'd5) && (min_u <= 4'd9) && (min_t <= 4'd5)
        && ((hr_t == 4'd0 && hr_u >= 4'd1 && hr_u <= 4'd9) || (hr_t == 4'd1 && hr_u <= 4'd2)));
endmodule

bind hms_clock12 hms_clock12_checks u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .set_en    (set_en),
    .set_hr_t  (set_hr_t),
    .set_hr_u  (set_hr_u),
    .set_min_t (set_min_t),
    .set_min_u (set_min_u),
    .sec_u     (sec_u),
    .sec_t     (sec_t),
    .min_u     (min_u),
    .min_t     (min_t),
    .hr_u      (hr_u),
    .hr_t      (hr_t),
    .pm        (pm)
);

// File: tb/hms_clock12_test.sv
// Self-checking bench: a seconds-since-midnight model predicts every output.
module hms_clock12_test;
    logic       clk = 1'b0;
    logic       rst_n, tick, set_en;
    logic [3:0] set_hr_t, set_hr_u, set_min_t, set_min_u;
    logic [3:0] sec_u, sec_t, min_u, min_t, hr_u, hr_t;
    logic       pm;

    int checks = 0;
    int fails  = 0;
    int model  = 0;     // seconds since 12:00:00 AM
    int cycles = 0;
    bit done   = 0;

    always #10 clk = ~clk;   // 50 MHz

    hms_clock12 uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .set_en(set_en),
        .set_hr_t(set_hr_t), .set_hr_u(set_hr_u),
        .set_min_t(set_min_t), .set_min_u(set_min_u),
        .sec_u(sec_u), .sec_t(sec_t), .min_u(min_u), .min_t(min_t),
        .hr_u(hr_u), .hr_t(hr_t), .pm(pm)
    );

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer than 150000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    function automatic logic [24:0] expect_of(int s);
        int h24, h12, m, sc;
        h24 = s / 3600;
        m   = (s / 60) % 60;
        sc  = s % 60;
        h12 = (h24 % 12 == 0) ? 12 : h24 % 12;
        return {4'(h12 / 10), 4'(h12 % 10), 4'(m / 10), 4'(m % 10),
                4'(sc / 10), 4'(sc % 10), (h24 >= 12)};
    endfunction

    task automatic check_now(string tag);
        logic [24:0] act, exp;
        act = {hr_t, hr_u, min_t, min_u, sec_t, sec_u, pm};
        exp = expect_of(model);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h%h:%h%h:%h%h pm=%b, expected %h%h:%h%h:%h%h pm=%b",
                     tag, act[24:21], act[20:17], act[16:13], act[12:9], act[8:5], act[4:1], act[0],
                     exp[24:21], exp[20:17], exp[16:13], exp[12:9], exp[8:5], exp[4:1], exp[0]);
        end
    endtask

    // One edge with the given inputs; outputs are read at the next falling edge.
    task automatic cycle(bit t, bit s, int ht, int hu, int mt, int mu);
        tick = t; set_en = s;
        set_hr_t = 4'(ht); set_hr_u = 4'(hu); set_min_t = 4'(mt); set_min_u = 4'(mu);
        @(negedge clk);
        tick = 0; set_en = 0;
    endtask

    task automatic run_ticks(int n);
        for (int k = 0; k < n; k++) begin
            cycle(1, 0, 0, 0, 0, 0);
            model = (model + 1) % 86400;
        end
    endtask

    // Model effect of a valid load: keeps the half of the day.
    task automatic model_set(int h12, int m);
        model = ((h12 % 12) + ((model >= 43200) ? 12 : 0)) * 3600 + m * 60;
    endtask

    initial begin
        rst_n = 0; tick = 1; set_en = 1;
        set_hr_t = 0; set_hr_u = 5; set_min_t = 3; set_min_u = 0;
        @(negedge clk);
        @(negedge clk);
        model = 0;
        check_now("R1 reset with tick and load held high");
        rst_n = 1;

        for (int k = 0; k < 5; k++) cycle(0, 0, 0, 0, 0, 0);
        check_now("R2 idle cycles hold");

        // Full day sweep, one compare per tick, tagged by the carry crossed.
        for (int k = 0; k < 86400; k++) begin
            int nx;
            string tag;
            nx = (model + 1) % 86400;
            if (nx % 43200 == 0)     tag = "R7 pm flip at 12:00:00";
            else if (nx % 3600 == 0) tag = "R6 hour step";
            else if (nx % 60 == 0)   tag = "R5 minute carry into hours path";
            else if (nx % 10 == 0)   tag = "R4 seconds tens step";
            else                     tag = "R3 seconds units step";
            cycle(1, 0, 0, 0, 0, 0);
            model = nx;
            check_now(tag);
        end
        check_now("R7 full day returns to 12:00:00 AM");
        check_now("R10 in-range digits after full day");

        // Valid load 11:59 in the morning, then cross into the afternoon.
        run_ticks(17);
        cycle(0, 1, 1, 1, 5, 9); model_set(11, 59);
        check_now("R8 load 11:59 clears seconds, keeps pm");
        run_ticks(59);
        check_now("R7 11:59:59 AM before flip");
        run_ticks(1);
        check_now("R7 11:59:59 to 12:00:00 PM");

        // 12:59:59 PM to 01:00:00 PM.
        cycle(0, 1, 1, 2, 5, 9); model_set(12, 59);
        check_now("R8 load 12:59 in afternoon");
        run_ticks(60);
        check_now("R6 12:59:59 to 01:00:00");

        // Load wins over tick in the same cycle.
        run_ticks(7);
        cycle(1, 1, 0, 9, 0, 5); model_set(9, 5);
        check_now("R8 load with tick gives seconds 00");

        // Out-of-range loads without tick change nothing.
        cycle(0, 1, 1, 3, 0, 0);  check_now("R9 hours 13 ignored");
        cycle(0, 1, 0, 0, 1, 0);  check_now("R9 hours 00 ignored");
        cycle(0, 1, 0, 4, 6, 0);  check_now("R9 minutes 60 ignored");
        cycle(0, 1, 0, 10, 1, 1); check_now("R9 hours units 0xA ignored");
        cycle(0, 1, 0, 4, 2, 10); check_now("R9 minutes units 0xA ignored");
        // With tick, an invalid load still lets the second advance.
        cycle(1, 1, 2, 1, 0, 0); model = (model + 1) % 86400;
        check_now("R9 invalid load with tick advances one second");

        // Load 12:00 in the afternoon keeps pm=1, and 12 followed by 01.
        cycle(0, 1, 1, 2, 0, 0); model_set(12, 0);
        check_now("R8 load 12:00 keeps afternoon");
        run_ticks(3600);
        check_now("R6 12 to 01 in afternoon");

        // Reset in the middle of a run.
        rst_n = 0;
        cycle(1, 0, 0, 0, 0, 0);
        rst_n = 1;
        model = 0;
        check_now("R1 reset mid-run");

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule